// File: doc/BRIEF.md
# Self-Synchronizing Parallel PRBS Checker

This block checks a pseudorandom bit stream built on a trinomial x^n + x^d + 1. The stream arrives as parallel words of any width. The checker needs no seed and no alignment step. It predicts each received bit from the bits that came n and d positions before it, and it raises a flag on any line where the received bit differs from the prediction. The earlier bits come from the current word or from a short history of the last n bits. That history carries the stream across word boundaries, so the word width may be smaller or larger than n.

The degree, the middle tap, the word width and an optional pre-check inversion are parameters. They are set to match the generator that feeds the link. One corrupted line bit raises three flags: one at the corrupted bit, one d bits later and one n bits later. After reset the flags stay masked until the first n bits have arrived. Flags are registered, so they appear one clock after the word that caused them.

Top module: `prbs_selfsync_chk`

## Requirements
- R1: A synchronous reset clears every error flag on the following clock and restarts the fill count from zero.
- R2: Let r[k] be the received bit k, after the optional inversion. Its flag is r[k] XOR r[k-n] XOR r[k-d]. A stream that obeys r[k] = r[k-n] XOR r[k-d] therefore gives all-zero flags once the history is full, whatever the stream's starting state.
- R3: Within a word, bit 0 is the oldest received bit and bit WIDTH-1 the newest. Flag bit j refers to input bit j.
- R4: A single inverted line bit at stream position k, with the history full, raises exactly three flags in total: at positions k, k+d and k+n.
- R5: Flags are registered. They change only on the clock edge that accepts the word, not while a word is being presented.
- R6: While the enable is low, no state changes: the flags hold their value and the history is unaffected by the data presented.
- R7: The flag for a bit is forced to zero when fewer than n bits have been accepted since reset before that bit.
- R8: With the inversion parameter set, the input word is complemented before the check, so an inverted stream gives zero flags.
- R9: Checking is correct both for word widths larger than n and for word widths smaller than n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable for all registers |
| din | input | WIDTH | Received word, bit 0 oldest |
| err | output | WIDTH | Per-line error flags, 1 = mismatch |

## Verification
The bench feeds the checker its own trinomial stream and injects single-bit errors at the first, last and middle lines of a word. A history that did not span word boundaries, or bit ordering that was reversed, would flag clean data or misplace the flags near word edges. Errors are also placed so that the flags at k+d and k+n fall into the next words; missing or extra flags there would show a history shifted by the wrong amount.

Directed cases cover several other faults. Garbage words just after reset would produce false flags if the fill masking were wrong. Data presented with the enable low would corrupt the history if the enable gating were broken. A second instance, narrower than n and inverting, gives all-ones flags if its inversion is dropped and wrong flags if the narrow-word history update is wrong.

// File: rtl/prbs_selfsync_chk.sv
module prbs_selfsync_chk #(
  parameter int POLY_N = 7,
  parameter int POLY_D = 6,
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] err
);

  localparam int EXT = POLY_N + WIDTH;
  localparam int CW  = $clog2(POLY_N + WIDTH + 1);

  logic [POLY_N-1:0] hist;
  logic [CW-1:0]     fill;
  logic [WIDTH-1:0]  rx, miss, ok;
  logic [EXT-1:0]    ext;
  logic [CW-1:0]     fsum;

  assign rx   = INVERT ? ~din : din;
  assign ext  = {rx, hist};
  assign fsum = fill + CW'(WIDTH);

  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    assign miss[j] = ext[POLY_N+j] ^ ext[j] ^ ext[POLY_N+j-POLY_D];
    assign ok[j]   = (fill + CW'(j)) >= CW'(POLY_N);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      fill <= '0;
      err  <= '0;
    end else if (en) begin
      hist <= ext[EXT-1:WIDTH];
      fill <= (fsum >= CW'(POLY_N)) ? CW'(POLY_N) : fsum;
      err  <= miss & ok;
    end
  end

endmodule

// File: rtl/prbs_chk_props.sv
module prbs_chk_props #(
  parameter int POLY_N = 7,
  parameter int WIDTH  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] err
);

  localparam int CW = $clog2(POLY_N + WIDTH + 1);
  localparam int FIRST_MAX = (WIDTH > POLY_N) ? WIDTH - POLY_N : 0;

  logic [CW-1:0] seen;
  logic [CW-1:0] nxt;
  assign nxt = seen + CW'(WIDTH);

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (en) seen <= (nxt >= CW'(POLY_N)) ? CW'(POLY_N) : nxt;
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> err == '0);

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(err));

  a_r7_masked_fill: assert property (@(posedge clk) disable iff (rst)
    en && ((seen + CW'(WIDTH)) <= CW'(POLY_N)) |=> err == '0);

  a_r7_first_word: assert property (@(posedge clk) disable iff (rst)
    en && seen == '0 |=> $countones(err) <= FIRST_MAX);

endmodule

bind prbs_selfsync_chk prbs_chk_props #(.POLY_N(POLY_N), .WIDTH(WIDTH)) u_props (
  .clk(clk), .rst(rst), .en(en), .err(err)
);

// File: tb/sim_prbs_selfsync_chk.sv
module sim_prbs_selfsync_chk;
  localparam int N  = 7;
  localparam int D  = 6;
  localparam int W0 = 8;
  localparam int W1 = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en0 = 1'b0, en1 = 1'b0;
  logic [W0-1:0] din0 = '0, err0;
  logic [W1-1:0] din1 = '0, err1;

  always #4 clk = ~clk;

  prbs_selfsync_chk #(.POLY_N(N), .POLY_D(D), .WIDTH(W0), .INVERT(1'b0)) u0 (
    .clk(clk), .rst(rst), .en(en0), .din(din0), .err(err0));
  prbs_selfsync_chk #(.POLY_N(N), .POLY_D(D), .WIDTH(W1), .INVERT(1'b1)) u1 (
    .clk(clk), .rst(rst), .en(en1), .din(din1), .err(err1));

  int total = 0, bad = 0;
  logic [N-1:0] g0 = 7'h5a, g1 = 7'h13;
  bit c0 [0:2047];
  bit c1 [0:2047];
  int k0 = 0, k1 = 0;

  // {clean words before, flip mask}
  localparam logic [15:0] TAB [6] = '{16'h0301, 16'h0280, 16'h0110,
                                      16'h0040, 16'h0208, 16'h0102};

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic word0(input logic [W0-1:0] flip, input string tag, output int ones);
    logic [W0-1:0] w, ex, prev;
    for (int j = 0; j < W0; j++) begin
      logic b;
      b = g0[N-1] ^ g0[D-1];
      g0 = {g0[N-2:0], b};
      w[j] = b ^ flip[j];
      c0[k0+j] = flip[j];
    end
    for (int j = 0; j < W0; j++) begin
      int k;
      k = k0 + j;
      if (k < N) ex[j] = 1'b0;
      else ex[j] = c0[k] ^ c0[k-N] ^ c0[k-D];
    end
    k0 += W0;
    prev = err0;
    din0 = w; en0 = 1'b1;
    #1;
    chk(err0 == prev, "R5 no change before edge", 16'(err0), 16'(prev));
    @(posedge clk); @(negedge clk);
    chk(err0 == ex, tag, 16'(err0), 16'(ex));
    ones = $countones(err0);
  endtask

  task automatic word1(input logic [W1-1:0] flip, input string tag, output int ones);
    logic [W1-1:0] w, ex;
    for (int j = 0; j < W1; j++) begin
      logic b;
      b = g1[N-1] ^ g1[D-1];
      g1 = {g1[N-2:0], b};
      w[j] = ~b ^ flip[j];
      c1[k1+j] = flip[j];
    end
    for (int j = 0; j < W1; j++) begin
      int k;
      k = k1 + j;
      if (k < N) ex[j] = 1'b0;
      else ex[j] = c1[k] ^ c1[k-N] ^ c1[k-D];
    end
    k1 += W1;
    din1 = w; en1 = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(err1 == ex, tag, 16'(err1), 16'(ex));
    ones = $countones(err1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en0 = 1'b0; en1 = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 2048; i++) begin c0[i] = 1'b0; c1[i] = 1'b0; end
    k0 = 0; k1 = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, sum;
    logic [W0-1:0] held;
    do_reset();
    @(negedge clk);
    chk(err0 == '0, "R1 reset state u0", 16'(err0), 16'h0);
    chk(err1 == '0, "R1 reset state u1", 16'(err1), 16'h0);

    // R7: garbage in the first word, only bit 7 is past the fill
    word0(8'hff, "R7 fill masking", n);
    word0(8'h00, "R7 after garbage", n);
    word0(8'h00, "R2 R3 clean stream", n);

    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < int'(TAB[t][15:8]); i++) word0(8'h00, "R2 R3 clean", n);
      sum = 0;
      word0(TAB[t][7:0], "R4 flag positions", n); sum += n;
      word0(8'h00, "R4 later flags", n); sum += n;
      word0(8'h00, "R4 later flags", n); sum += n;
      chk(sum == $countones(TAB[t][7:0]) * 3, "R4 three flags per error",
          16'(sum), 16'($countones(TAB[t][7:0]) * 3));
    end

    // R6: enable low with junk data
    word0(8'h04, "R4 flag positions", n);
    held = err0;
    din0 = 8'hc3; en0 = 1'b0;
    @(posedge clk); @(negedge clk);
    din0 = 8'h3c;
    @(posedge clk); @(negedge clk);
    chk(err0 == held, "R6 hold while disabled", 16'(err0), 16'(held));
    word0(8'h00, "R6 history untouched", n);
    word0(8'h00, "R6 history untouched", n);

    // R1: reset mid-stream, generator keeps running (no seed needed)
    do_reset();
    @(negedge clk);
    chk(err0 == '0, "R1 cleared mid-stream", 16'(err0), 16'h0);
    word0(8'hff, "R1 R7 refill masking", n);
    word0(8'h00, "R2 resync", n);

    // R8 R9: narrow inverting instance
    for (int i = 0; i < 8; i++) word1(3'b000, "R8 R9 clean inverted narrow", n);
    sum = 0;
    word1(3'b010, "R9 narrow error", n); sum += n;
    for (int i = 0; i < 4; i++) begin word1(3'b000, "R9 narrow later", n); sum += n; end
    chk(sum == 3, "R9 narrow three flags", 16'(sum), 16'd3);
    for (int i = 0; i < 3; i++) word1(3'b000, "R8 clean again", n);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule